// File: doc/BRIEF.md
# Error Capture and Reporting Unit

The unit gathers error events from a processor-bus interface and a PCI interface into two 8-bit flag registers, bank A and bank B. Each bank has a matching enable register. An error event is latched only if its enable bit is set. Any latched error raises a level machine-check output. A processor-bus error can also raise a one-cycle transfer-error abort pulse, if the abort control bit allows it.

The first accepted error takes a snapshot of the error address, the processor-bus status word and the PCI-bus status word. Two attribute bits are written at the same moment:
- the source bit, bank A bit 3: 0 means a processor-bus cycle, 1 means a PCI cycle;
- the address-invalid bit, bank B bit 7.

Later errors still set their own flags, but they leave the snapshot alone. The snapshot is released once software has cleared every bit of both banks through write-one-to-clear writes.

By convention, the upstream detectors use bank A bits 1..0 for the unsupported-transaction type code, bank B bit 5 for an illegal L2 copy-back and bank B bit 0 for a flash write error. The unit treats all non-attribute bit positions alike.

Top module: `err_capture_unit`

## Requirements
- R1: After reset, every readable register reads zero and `mcp_o` and `tea_o` are low.
- R2: An event bit whose enable bit is set sets that flag on the next clock edge. The flag stays set until a write of 1 to that bit at register 0 (bank A) or register 1 (bank B). If a set and a clear hit the same bit in the same cycle, the set wins.
- R3: An accepted error captures `err_addr_i`, `cpu_stat_i` and `pci_stat_i` when both banks are all zero after that cycle's clear is applied.
- R4: While any flag bit remains set, the captured address and status do not change, even when later accepted errors set new flags.
- R5: `mcp_o` is high exactly while any non-attribute flag bit in either bank is set.
- R6: An event whose enable bit is clear sets no flag, changes no capture and raises neither output.
- R7: `tea_o` pulses for one cycle, on the cycle after an accepted error with `err_pci_i`=0, when control bit 0 is set. It stays low for PCI-source errors and when control bit 0 is clear.
- R8: At capture, bank A bit 3 takes the value of `err_pci_i`, and bank B bit 7 takes `err_pci_i & err_addr_bad_i`. Event inputs at these two positions are ignored.
- R9: An accepted error that arrives in the same cycle as the write clearing the last set flag is captured as a new first error.
- R10: The register map is as follows. Reads are combinational.

| Address | Contents |
|---|---|
| 0 | bank A flags |
| 1 | bank B flags |
| 2 | bank A enables |
| 3 | bank B enables |
| 4 | control: bit 0 is the abort enable |
| 5 | captured address |
| 6 | PCI status in bits 15..8, processor status in bits 7..0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_a_i | input | 8 | Bank A error event pulses |
| err_b_i | input | 8 | Bank B error event pulses |
| err_pci_i | input | 1 | The event comes from a PCI cycle |
| err_addr_bad_i | input | 1 | The event address is not valid |
| err_addr_i | input | 32 | Address of the failing cycle |
| cpu_stat_i | input | 8 | Processor-bus status of the failing cycle |
| pci_stat_i | input | 8 | PCI-bus status of the failing cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| mcp_o | output | 1 | Machine-check request, level |
| tea_o | output | 1 | Transfer-error abort, pulse |

## Verification
A wrong capture-hold state shows up on the first read of register 5 or 6 after a second error. There the address of the later error would appear in place of the first one. A stuck or lost flag shows on `mcp_o` one cycle after the event, and in the bank read of that same cycle. A bad arming decision is exposed by an error that arrives with the final clear: the capture then either misses the new address or takes it one cycle too late. The bench hits this case directly and also reaches it repeatedly under random clears.

// File: rtl/ecu_pkg.sv
`timescale 1ns/1ps
package ecu_pkg;
  localparam int FLAG_W  = 8;
  localparam int SRC_BIT = 3;
  localparam int INV_BIT = 7;
  typedef enum logic [2:0] {
    RA_DET_A = 3'd0,
    RA_DET_B = 3'd1,
    RA_EN_A  = 3'd2,
    RA_EN_B  = 3'd3,
    RA_CTL   = 3'd4,
    RA_ADDR  = 3'd5,
    RA_STAT  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/ecu_flag_bank.sv
`timescale 1ns/1ps
module ecu_flag_bank #(
  parameter int           W         = 8,
  parameter logic [W-1:0] ATTR_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] attr_set_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] acc_o,
  output logic         rem_zero_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] keep_w;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // attribute positions are written only by the capture path
    assign acc_o[b]  = evt_i[b] & en_i[b] & ~ATTR_MASK[b];
    assign keep_w[b] = flags_q[b] & ~clr_i[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[b] <= 1'b0;
      else         flags_q[b] <= keep_w[b] | acc_o[b] | attr_set_i[b];
    end
  end

  assign flags_o    = flags_q;
  assign rem_zero_o = ~|keep_w;
endmodule

// File: rtl/ecu_snap.sv
`timescale 1ns/1ps
module ecu_snap #(
  parameter int ADDR_W = 32,
  parameter int CS_W   = 8,
  parameter int PS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [PS_W-1:0]   ps_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CS_W-1:0]   cs_o,
  output logic [PS_W-1:0]   ps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cs_o   <= '0;
      ps_o   <= '0;
    end else if (cap_i) begin
      addr_o <= addr_i;
      cs_o   <= cs_i;
      ps_o   <= ps_i;
    end
  end
endmodule

// File: rtl/ecu_regif.sv
`timescale 1ns/1ps
module ecu_regif
  import ecu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CS_W   = 8,
  parameter int PS_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] det_a_i,
  input  logic [FLAG_W-1:0] det_b_i,
  input  logic [ADDR_W-1:0] snap_addr_i,
  input  logic [CS_W-1:0]   snap_cs_i,
  input  logic [PS_W-1:0]   snap_ps_i,
  output logic [FLAG_W-1:0] clr_a_o,
  output logic [FLAG_W-1:0] clr_b_o,
  output logic [FLAG_W-1:0] en_a_o,
  output logic [FLAG_W-1:0] en_b_o,
  output logic              abort_en_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(addr_i);

  assign clr_a_o = (we_i && ra == RA_DET_A) ? wdata_i : '0;
  assign clr_b_o = (we_i && ra == RA_DET_B) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_a_o     <= '0;
      en_b_o     <= '0;
      abort_en_o <= 1'b0;
    end else if (we_i) begin
      if (ra == RA_EN_A) en_a_o     <= wdata_i;
      if (ra == RA_EN_B) en_b_o     <= wdata_i;
      if (ra == RA_CTL)  abort_en_o <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (ra)
      RA_DET_A: rdata_o[FLAG_W-1:0] = det_a_i;
      RA_DET_B: rdata_o[FLAG_W-1:0] = det_b_i;
      RA_EN_A:  rdata_o[FLAG_W-1:0] = en_a_o;
      RA_EN_B:  rdata_o[FLAG_W-1:0] = en_b_o;
      RA_CTL:   rdata_o[0]          = abort_en_o;
      RA_ADDR:  rdata_o[ADDR_W-1:0] = snap_addr_i;
      RA_STAT:  rdata_o[CS_W+PS_W-1:0] = {snap_ps_i, snap_cs_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/err_capture_unit.sv
`timescale 1ns/1ps
module err_capture_unit
  import ecu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CS_W   = 8,
  parameter int PS_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] err_a_i,
  input  logic [FLAG_W-1:0] err_b_i,
  input  logic              err_pci_i,
  input  logic              err_addr_bad_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [CS_W-1:0]   cpu_stat_i,
  input  logic [PS_W-1:0]   pci_stat_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [FLAG_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mcp_o,
  output logic              tea_o
);
  localparam logic [FLAG_W-1:0] ATTR_A = FLAG_W'(1) << SRC_BIT;
  localparam logic [FLAG_W-1:0] ATTR_B = FLAG_W'(1) << INV_BIT;

  logic [FLAG_W-1:0] det_a_q, det_b_q, acc_a, acc_b;
  logic [FLAG_W-1:0] clr_a, clr_b, en_a, en_b, attr_a, attr_b;
  logic              rz_a, rz_b, first_w, acc_any, cap_w, abort_en, tea_q;
  logic [ADDR_W-1:0] snap_addr;
  logic [CS_W-1:0]   snap_cs;
  logic [PS_W-1:0]   snap_ps;

  // first error: nothing left set once this cycle's clear is applied
  assign first_w = rz_a & rz_b;
  assign acc_any = (|acc_a) | (|acc_b);
  assign cap_w   = acc_any & first_w;
  assign attr_a  = (cap_w && err_pci_i) ? ATTR_A : '0;
  assign attr_b  = (cap_w && err_pci_i && err_addr_bad_i) ? ATTR_B : '0;

  ecu_flag_bank #(.W(FLAG_W), .ATTR_MASK(ATTR_A)) u_bank_a (
    .clk_i, .rst_ni, .evt_i(err_a_i), .en_i(en_a), .clr_i(clr_a),
    .attr_set_i(attr_a), .flags_o(det_a_q), .acc_o(acc_a), .rem_zero_o(rz_a)
  );

  ecu_flag_bank #(.W(FLAG_W), .ATTR_MASK(ATTR_B)) u_bank_b (
    .clk_i, .rst_ni, .evt_i(err_b_i), .en_i(en_b), .clr_i(clr_b),
    .attr_set_i(attr_b), .flags_o(det_b_q), .acc_o(acc_b), .rem_zero_o(rz_b)
  );

  ecu_snap #(.ADDR_W(ADDR_W), .CS_W(CS_W), .PS_W(PS_W)) u_snap (
    .clk_i, .rst_ni, .cap_i(cap_w), .addr_i(err_addr_i), .cs_i(cpu_stat_i),
    .ps_i(pci_stat_i), .addr_o(snap_addr), .cs_o(snap_cs), .ps_o(snap_ps)
  );

  ecu_regif #(.ADDR_W(ADDR_W), .CS_W(CS_W), .PS_W(PS_W), .DATA_W(DATA_W)) u_regif (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .det_a_i(det_a_q), .det_b_i(det_b_q), .snap_addr_i(snap_addr),
    .snap_cs_i(snap_cs), .snap_ps_i(snap_ps), .clr_a_o(clr_a), .clr_b_o(clr_b),
    .en_a_o(en_a), .en_b_o(en_b), .abort_en_o(abort_en), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tea_q <= 1'b0;
    else         tea_q <= acc_any & ~err_pci_i & abort_en;
  end

  assign tea_o = tea_q;
  assign mcp_o = (|(det_a_q & ~ATTR_A)) | (|(det_b_q & ~ATTR_B));
endmodule

// File: rtl/ecu_chk.sv
`timescale 1ns/1ps
module ecu_chk #(
  parameter int ADDR_W = 32,
  parameter int FW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FW-1:0]     det_a_q,
  input logic [FW-1:0]     det_b_q,
  input logic              acc_any,
  input logic              first_w,
  input logic              cap_w,
  input logic [ADDR_W-1:0] snap_addr,
  input logic [ADDR_W-1:0] err_addr_i,
  input logic              err_pci_i,
  input logic              mcp_o,
  input logic              tea_o
);
  AST_CAP_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_w |=> snap_addr == $past(err_addr_i)); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_w |=> $stable(snap_addr)); // R4
  AST_MCP_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_any |=> mcp_o); // R5
  AST_NO_NEW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_any |=> ((det_a_q & ~$past(det_a_q)) == '0 && (det_b_q & ~$past(det_b_q)) == '0)); // R6
  AST_PCI_NO_TEA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_any && err_pci_i) |=> !tea_o); // R7
  AST_CPU_ATTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_w && !err_pci_i) |=> (!det_a_q[3] && !det_b_q[7])); // R8
endmodule

bind err_capture_unit ecu_chk #(.ADDR_W(ADDR_W), .FW(ecu_pkg::FLAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .det_a_q(det_a_q), .det_b_q(det_b_q),
  .acc_any(acc_any), .first_w(first_w), .cap_w(cap_w), .snap_addr(snap_addr),
  .err_addr_i(err_addr_i), .err_pci_i(err_pci_i), .mcp_o(mcp_o), .tea_o(tea_o)
);

// File: tb/tb_err_capture_unit.sv
`timescale 1ns/100ps
module tb_err_capture_unit;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  err_a_i = '0, err_b_i = '0;
  logic        err_pci_i = 1'b0, err_addr_bad_i = 1'b0;
  logic [31:0] err_addr_i = '0;
  logic [7:0]  cpu_stat_i = '0, pci_stat_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mcp_o, tea_o;

  err_capture_unit dut (.*);

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;
  // model state
  logic [7:0]  m_a = '0, m_b = '0, m_ena = '0, m_enb = '0;
  logic        m_ctl = 1'b0, m_tea = 1'b0;
  logic [31:0] m_addr = '0;
  logic [7:0]  m_cs = '0, m_ps = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_exp(input int a);
    case (a)
      0: return {24'd0, m_a};
      1: return {24'd0, m_b};
      2: return {24'd0, m_ena};
      3: return {24'd0, m_enb};
      4: return {31'd0, m_ctl};
      5: return m_addr;
      6: return {16'd0, m_ps, m_cs};
      default: return '0;
    endcase
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " mcp R5"}, {31'd0, mcp_o}, {31'd0, (|(m_a & 8'hF7)) | (|(m_b & 8'h7F))});
    chk({tag, " tea R7"}, {31'd0, tea_o}, {31'd0, m_tea});
    for (int a = 0; a < 7; a++) begin
      reg_addr_i = a[2:0];
      #0.4;
      chk($sformatf("%s reg%0d R10", tag, a), reg_rdata_o, reg_exp(a));
    end
  endtask

  // apply one cycle of stimulus, update model, then check
  task automatic step(input string tag, input logic [7:0] ea, input logic [7:0] eb,
                      input logic pci, input logic badadr, input logic [31:0] ad,
                      input logic [7:0] cs, input logic [7:0] ps,
                      input logic we, input logic [2:0] wa, input logic [7:0] wd);
    logic [7:0] clr_a, clr_b, acc_a, acc_b;
    logic first, cap, any;
    err_a_i = ea; err_b_i = eb; err_pci_i = pci; err_addr_bad_i = badadr;
    err_addr_i = ad; cpu_stat_i = cs; pci_stat_i = ps;
    reg_we_i = we; reg_addr_i = wa; reg_wdata_i = wd;
    clr_a = (we && wa == 3'd0) ? wd : 8'h00;
    clr_b = (we && wa == 3'd1) ? wd : 8'h00;
    acc_a = ea & m_ena & 8'hF7;
    acc_b = eb & m_enb & 8'h7F;
    any   = (acc_a != 0) || (acc_b != 0);
    first = ((m_a & ~clr_a) == 0) && ((m_b & ~clr_b) == 0);
    cap   = any && first;
    m_tea = any && !pci && m_ctl;
    m_a = (m_a & ~clr_a) | acc_a | ((cap && pci) ? 8'h08 : 8'h00);
    m_b = (m_b & ~clr_b) | acc_b | ((cap && pci && badadr) ? 8'h80 : 8'h00);
    if (cap) begin m_addr = ad; m_cs = cs; m_ps = ps; end
    if (we && wa == 3'd2) m_ena = wd;
    if (we && wa == 3'd3) m_enb = wd;
    if (we && wa == 3'd4) m_ctl = wd[0];
    @(posedge clk_i);
    @(negedge clk_i);
    err_a_i = '0; err_b_i = '0; reg_we_i = 1'b0;
    check_all(tag);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0, 8'h0, 8'h0, 1'b1, a, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 post");
    wr("R10 en_a", 3'd2, 8'hFF);
    wr("R10 en_b", 3'd3, 8'h00);
    wr("R10 ctl", 3'd4, 8'h01);
    // R6: disabled bank B events leave everything untouched
    step("R6 disabled", 8'h00, 8'h21, 1'b0, 1'b0, 32'hDEAD_0001, 8'h11, 8'h22, 1'b0, 3'd0, 8'h0);
    wr("R10 en_b2", 3'd3, 8'hFF);
    // R3/R8: processor-bus first error, invalid-address flag must stay clear
    step("R3 first", 8'h01, 8'h00, 1'b0, 1'b1, 32'hA000_0001, 8'h31, 8'h41, 1'b0, 3'd0, 8'h0);
    // R4: later error keeps capture
    step("R4 later", 8'h00, 8'h20, 1'b1, 1'b1, 32'hA000_0002, 8'h32, 8'h42, 1'b0, 3'd0, 8'h0);
    step("R4 partial clr", 8'h00, 8'h00, 1'b0, 1'b0, 32'h0, 8'h0, 8'h0, 1'b1, 3'd0, 8'hFF);
    // R2: set wins over same-cycle clear
    step("R2 set wins", 8'h00, 8'h01, 1'b0, 1'b0, 32'hA000_0004, 8'h0, 8'h0, 1'b1, 3'd1, 8'h01);
    // R9: event with final clear is a new first error (PCI, bad address)
    step("R9 reuse", 8'h02, 8'h00, 1'b1, 1'b1, 32'hA000_0003, 8'h33, 8'h43, 1'b1, 3'd1, 8'hFF);
    chk("R9 addr", reg_rdata_o, 32'h0000_4333);
    // R8: event input at attribute positions ignored
    step("R8 attr in", 8'h08, 8'h80, 1'b0, 1'b0, 32'hA000_0005, 8'h0, 8'h0, 1'b0, 3'd0, 8'h0);
    wr("R2 clr a", 3'd0, 8'hFF);
    wr("R2 clr b", 3'd1, 8'hFF);
    chk("R2 mcp low", {31'd0, mcp_o}, 32'd0);
    wr("R7 ctl off", 3'd4, 8'h00);
    step("R7 no tea", 8'h04, 8'h00, 1'b0, 1'b0, 32'hA000_0006, 8'h1, 8'h2, 1'b0, 3'd0, 8'h0);
    wr("R7 ctl on", 3'd4, 8'h01);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ea, eb, wd;
      logic we;
      logic [2:0] wa;
      ea = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      eb = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      we = ($urandom % 3 == 0);
      wa = 3'($urandom % 5);
      wd = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
      if (wa >= 3'd2 && $urandom % 2 == 0) wa = 3'($urandom % 2);
      step("R2 rnd", ea, eb, 1'($urandom), 1'($urandom), $urandom,
           8'($urandom), 8'($urandom), we, wa, wd);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule